// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by fixed priority and raises one interrupt output toward a processor. The processor answers with a one-cycle acknowledge. The controller then returns an 8-bit vector for the winning level, or names a cascaded slave on a 3-bit cascade bus so that the slave supplies the vector. Software talks to it through two byte-wide ports. The command port takes the start of initialisation, end-of-interrupt commands and a readback selector. The data port takes the rest of the initialisation words and, after that, the mask register.

After reset, a command word with bit 4 set begins initialisation. The next three data-port writes give the vector base, the cascade word and the mode word. In master role the cascade word is a bitmask of the inputs that carry a slave. In slave role its low three bits are the slave's identity. The role itself is a strap input. Bit 1 of the mode word selects automatic end of interrupt. Requests are edge triggered. Level 0 has the highest priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the data port reads 0xFF (all inputs masked), the interrupt output is low and the command port reads 0x00.
- R2: A command write with bit 4 set clears the request and in-service registers and selects request readback. The next three data writes load the base, the cascade word and the mode word without altering the mask. No interrupt is raised before the third word.
- R3: Once initialised, a data-port write sets the mask, which reads back unchanged. With no data write the mask holds.
- R4: A rising edge on an input sets its request bit. The bit stays set until that level is acknowledged.
- R5: On acknowledge the vector is the base plus the number of the highest-priority unmasked pending level, with level 0 highest.
- R6: The interrupt output is high only when an unmasked pending level is numerically lower than every in-service level.
- R7: On a real acknowledge, the cycle after the acknowledge presents vec_valid with the vector. The level's request bit clears and its in-service bit sets.
- R8: A command write of 0x60 plus n (n = 0..7) clears in-service bit n only.
- R9: A command write of 0x0B makes the command port read the in-service register. A write of 0x0A makes it read the request register.
- R10: With mode-word bit 1 set, an acknowledge delivers the vector but leaves the in-service register unchanged.
- R11: An acknowledge while the interrupt output is low returns base plus 7 and leaves the in-service register unchanged.
- R12: In master role, acknowledging a level whose cascade-word bit is set gives no vector. In the next cycle cas_drive is high and cas_out holds the level. The in-service bit is set.
- R13: In slave role the controller answers an acknowledge only when cas_in equals the low three bits of its cascade word. Otherwise nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command port |
| data_wr | input | 1 | Write strobe for the data port |
| wdata | input | 8 | Write data for both ports |
| cmd_rdata | output | 8 | Command-port read: request or in-service register |
| data_rdata | output | 8 | Data-port read: mask register |
| irq_in | input | 8 | Edge-triggered request inputs, bit 0 highest priority |
| slave_mode | input | 1 | Role strap: 0 master, 1 slave |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle interrupt acknowledge |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | 8 | Interrupt vector |
| cas_drive | output | 1 | Master is naming a slave on cas_out |
| cas_out | output | 3 | Cascade level presented by the master |

## Verification
The bench goes after the case where a request is masked or withdrawn before the acknowledge. A design that skipped the spurious path would return a stale level or set an in-service bit that no end-of-interrupt command ever clears. It nests a higher level over a lower one in service and then ends them in turn. A design that ranked against only the request register would let a lower level preempt, and an end-of-interrupt command that cleared the wrong bit would leave later levels blocked. It also checks automatic end of interrupt, master cascade hand-off and slave identity matching. In those cases a wrong design would either drive a vector on the wrong side of the cascade or answer an acknowledge that addressed another slave.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    CFG_RUN  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2,
    CFG_MODE = 2'd3
  } cfg_state_e;

  localparam int          INIT_BIT     = 4;
  localparam int          AEOI_BIT     = 1;
  localparam logic [4:0]  EOI_TAG      = 5'b01100;
  localparam logic [6:0]  RDSEL_TAG    = 7'b0000101;
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          init_start,
  output logic          init_done,
  output logic          aeoi,
  output logic          sel_isr,
  output logic          eoi_hit,
  output logic [LW-1:0] eoi_lvl,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_word,
  output logic [DW-1:0] mask
);
  cfg_state_e state_q, state_d;
  logic done_d;
  logic base_en, casc_en, mode_en, mask_en, sel_hit, sel_d;

  always_comb begin
    init_start = cmd_wr & wdata[INIT_BIT];
    eoi_hit    = cmd_wr & ~wdata[INIT_BIT] & (wdata[7:3] == EOI_TAG) & init_done;
    eoi_lvl    = wdata[LW-1:0];
    sel_hit    = cmd_wr & ~wdata[INIT_BIT] & (wdata[7:1] == RDSEL_TAG);
    state_d    = state_q;
    done_d     = init_done;
    base_en    = 1'b0;
    casc_en    = 1'b0;
    mode_en    = 1'b0;
    mask_en    = 1'b0;
    if (init_start) begin
      state_d = CFG_BASE;
      done_d  = 1'b0;
    end else if (data_wr) begin
      unique case (state_q)
        CFG_RUN:  mask_en = 1'b1;
        CFG_BASE: begin base_en = 1'b1; state_d = CFG_CASC; end
        CFG_CASC: begin casc_en = 1'b1; state_d = CFG_MODE; end
        CFG_MODE: begin mode_en = 1'b1; state_d = CFG_RUN; done_d = 1'b1; end
        default:  state_d = CFG_RUN;
      endcase
    end
    if (init_start)   sel_d = 1'b0;
    else if (sel_hit) sel_d = wdata[0];
    else              sel_d = sel_isr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CFG_RUN;
      init_done <= 1'b0;
      sel_isr   <= 1'b0;
      aeoi      <= 1'b0;
      vec_base  <= '0;
      casc_word <= '0;
      mask      <= '1;
    end else begin
      state_q   <= state_d;
      init_done <= done_d;
      sel_isr   <= sel_d;
      if (base_en) vec_base  <= wdata;
      if (casc_en) casc_word <= wdata;
      if (mode_en) aeoi      <= wdata[AEOI_BIT];
      if (mask_en) mask      <= wdata;
    end
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [LW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_rdata,
  output logic [DW-1:0] data_rdata,
  input  logic [N_IN-1:0] irq_in,
  input  logic          slave_mode,
  input  logic [2:0]    cas_in,
  output logic          int_out,
  input  logic          inta,
  output logic          vec_valid,
  output logic [DW-1:0] vec_out,
  output logic          cas_drive,
  output logic [2:0]    cas_out
);
  localparam int LW = $clog2(N_IN);
  localparam logic [LW-1:0] LVL_LOW = LW'(N_IN - 1);

  logic          init_start, init_done, aeoi, sel_isr, eoi_hit;
  logic [LW-1:0] eoi_lvl;
  logic [DW-1:0] vec_base, casc_word, mask;

  logic [N_IN-1:0] irq_prev, irr_q, isr_q, irr_d, isr_d, pend, lvl_bit;
  logic          p_hit, s_hit, sel_me, ack_go, ack_real, to_slave;
  logic [LW-1:0] p_idx, s_idx, lvl;
  logic          vec_valid_d, cas_drive_d;

  prio_irq_cfg #(.DW(DW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wdata(wdata),
    .init_start(init_start), .init_done(init_done), .aeoi(aeoi), .sel_isr(sel_isr),
    .eoi_hit(eoi_hit), .eoi_lvl(eoi_lvl), .vec_base(vec_base),
    .casc_word(casc_word), .mask(mask)
  );

  assign pend = irr_q & ~mask[N_IN-1:0];

  prio_irq_pick #(.N(N_IN), .LW(LW)) u_pick_req (.req(pend),  .hit(p_hit), .idx(p_idx));
  prio_irq_pick #(.N(N_IN), .LW(LW)) u_pick_svc (.req(isr_q), .hit(s_hit), .idx(s_idx));

  always_comb begin
    int_out   = init_done & p_hit & (~s_hit | (p_idx < s_idx));
    sel_me    = slave_mode ? (cas_in == casc_word[2:0]) : 1'b1;
    ack_go    = inta & init_done & sel_me;
    ack_real  = ack_go & int_out;
    lvl       = int_out ? p_idx : LVL_LOW;
    lvl_bit   = N_IN'(1) << lvl;
    to_slave  = ack_real & ~slave_mode & casc_word[lvl];

    irr_d = irr_q | (irq_in & ~irq_prev);
    if (ack_real) irr_d = irr_d & ~lvl_bit;
    isr_d = isr_q;
    if (eoi_hit) isr_d = isr_d & ~(N_IN'(1) << eoi_lvl);
    if (ack_real && !aeoi) isr_d = isr_d | lvl_bit;
    if (init_start) begin
      irr_d = '0;
      isr_d = '0;
    end

    vec_valid_d = ack_go & ~to_slave;
    cas_drive_d = to_slave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev  <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      vec_valid <= 1'b0;
      cas_drive <= 1'b0;
      vec_out   <= '0;
      cas_out   <= '0;
    end else begin
      irq_prev  <= irq_in;
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      vec_valid <= vec_valid_d;
      cas_drive <= cas_drive_d;
      if (ack_go) begin
        vec_out <= vec_base + DW'(lvl);
        cas_out <= 3'(lvl);
      end
    end
  end

  assign cmd_rdata  = sel_isr ? DW'(isr_q) : DW'(irr_q);
  assign data_rdata = mask;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       data_wr,
  input logic [7:0] wdata,
  input logic [7:0] data_rdata,
  input logic       slave_mode,
  input logic       int_out,
  input logic       inta,
  input logic       vec_valid,
  input logic [7:0] vec_out,
  input logic       cas_drive,
  input logic [2:0] cas_out,
  input logic       init_done,
  input logic [7:0] isr,
  input logic [7:0] base,
  input logic [7:0] casc
);
  assert_init_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[4]) |=> !int_out);

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(data_rdata));

  assert_ack_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !slave_mode) |=> (vec_valid || cas_drive));

  assert_eoi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cmd_wr && !wdata[4] && wdata[7:3] == 5'b01100 && !inta)
      |=> !isr[$past(wdata[2:0])]);

  assert_spurious_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !slave_mode && init_done)
      |=> (vec_valid && vec_out == $past(base) + 8'd7));

  assert_cascade_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cas_drive |-> casc[cas_out]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wdata(wdata),
  .data_rdata(data_rdata), .slave_mode(slave_mode), .int_out(int_out), .inta(inta),
  .vec_valid(vec_valid), .vec_out(vec_out), .cas_drive(cas_drive), .cas_out(cas_out),
  .init_done(init_done), .isr(isr_q), .base(vec_base), .casc(casc_word)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, cmd_wr, data_wr, slave_mode, inta;
  logic [7:0] wdata, irq_in;
  logic [2:0] cas_in;
  logic [7:0] cmd_rdata, data_rdata, vec_out;
  logic       int_out, vec_valid, cas_drive;
  logic [2:0] cas_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_irr, m_isr, m_mask, m_base;

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wdata(wdata),
    .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .irq_in(irq_in),
    .slave_mode(slave_mode), .cas_in(cas_in), .int_out(int_out), .inta(inta),
    .vec_valid(vec_valid), .vec_out(vec_out), .cas_drive(cas_drive), .cas_out(cas_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] v);
    cmd_wr = 1'b1; wdata = v; tick(); cmd_wr = 1'b0;
  endtask

  task automatic dat(input logic [7:0] v);
    data_wr = 1'b1; wdata = v; tick(); data_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    irq_in = v; tick(); irq_in = 8'h00; tick();
  endtask

  task automatic ack();
    inta = 1'b1; tick(); inta = 1'b0;
  endtask

  task automatic setup(input logic [7:0] base, input logic [7:0] casc, input logic [7:0] mode);
    cmd(8'h11); dat(base); dat(casc); dat(mode);
    m_base = base; m_irr = 8'h00; m_isr = 8'h00;
  endtask

  function automatic int top_lvl(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    int p = top_lvl(m_irr & ~m_mask);
    return (p < 8) && (p < top_lvl(m_isr));
  endfunction

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; data_wr = 1'b0; wdata = 8'h00; irq_in = 8'h00;
    slave_mode = 1'b0; inta = 1'b0; cas_in = 3'd0;
    void'($urandom(32'h0000_5EED));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 mask", data_rdata, 8'hFF);
    chk("R1 int", int_out, 0);
    chk("R1 cmd", cmd_rdata, 8'h00);

    // R2: edge before init, then init must clear it and keep mask
    pulse(8'h01);
    chk("R2 no int before init", int_out, 0);
    cmd(8'h11);
    chk("R2 irr cleared", cmd_rdata, 8'h00);
    dat(8'h20); dat(8'h00);
    chk("R2 mask untouched", data_rdata, 8'hFF);
    dat(8'h01);
    m_base = 8'h20; m_irr = 0; m_isr = 0; m_mask = 8'hFF;
    chk("R2 quiet after init", int_out, 0);

    dat(8'h5A); m_mask = 8'h5A;
    chk("R3 mask readback", data_rdata, 8'h5A);

    // random phase: R4 R5 R6 R7 R8 R11
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: begin
          logic [7:0] r = 8'($urandom);
          pulse(r); m_irr |= r;
          chk("R4 irr after edge", cmd_rdata, m_irr);
        end
        1: begin
          logic [7:0] m = 8'($urandom) & 8'($urandom);
          dat(m); m_mask = m;
          chk("R3 mask", data_rdata, m_mask);
        end
        2: begin
          logic real_i = exp_int();
          int lv = real_i ? top_lvl(m_irr & ~m_mask) : 7;
          chk("R6 int before ack", int_out, real_i);
          ack();
          chk("R7 vec_valid", vec_valid, 1);
          chk(real_i ? "R5 vector" : "R11 spurious vector", vec_out, m_base + 8'(lv));
          if (real_i) begin
            m_irr[lv] = 1'b0; m_isr[lv] = 1'b1;
          end
          tick();
          chk("R7 irr after ack", cmd_rdata, m_irr);
        end
        default: begin
          int l = $urandom_range(0, 7);
          cmd(8'h60 | 8'(l)); m_isr[l] = 1'b0;
          chk("R8 int after eoi", int_out, exp_int());
        end
      endcase
      chk("R6 int", int_out, exp_int());
    end

    // directed nesting
    setup(8'h40, 8'h00, 8'h01);
    dat(8'h00);
    pulse(8'h08); ack();
    chk("R5 lvl3 vector", vec_out, 8'h43);
    pulse(8'h20);
    chk("R6 lower blocked", int_out, 0);
    pulse(8'h02);
    chk("R6 higher preempts", int_out, 1);
    ack();
    chk("R5 lvl1 vector", vec_out, 8'h41);
    cmd(8'h0B);
    chk("R9 isr view", cmd_rdata, 8'h0A);
    cmd(8'h61);
    chk("R8 only lvl1 cleared", cmd_rdata, 8'h08);
    chk("R6 lvl5 still blocked", int_out, 0);
    cmd(8'h63);
    chk("R8 lvl3 cleared", cmd_rdata, 8'h00);
    chk("R6 lvl5 now", int_out, 1);
    cmd(8'h0A);
    chk("R9 irr view", cmd_rdata, 8'h20);
    ack();
    chk("R5 lvl5 vector", vec_out, 8'h45);
    cmd(8'h65);

    // spurious: request masked before acknowledge
    pulse(8'h10);
    dat(8'hFF);
    ack();
    chk("R11 vec_valid", vec_valid, 1);
    chk("R11 vector", vec_out, 8'h47);
    cmd(8'h0B);
    chk("R11 isr unchanged", cmd_rdata, 8'h00);

    // auto end of interrupt
    setup(8'h50, 8'h00, 8'h03);
    dat(8'h00);
    pulse(8'h04); ack();
    chk("R10 vector", vec_out, 8'h52);
    cmd(8'h0B);
    chk("R10 isr empty", cmd_rdata, 8'h00);

    // master cascade
    setup(8'h08, 8'h04, 8'h01);
    pulse(8'h04); ack();
    chk("R12 no vector", vec_valid, 0);
    chk("R12 cas_drive", cas_drive, 1);
    chk("R12 cas_out", cas_out, 3'd2);
    cmd(8'h0B);
    chk("R12 isr set", cmd_rdata, 8'h04);
    cmd(8'h62);
    pulse(8'h01); ack();
    chk("R12 plain vector", vec_valid, 1);
    chk("R12 plain no cas", cas_drive, 0);
    chk("R12 plain vec", vec_out, 8'h08);

    // slave role
    slave_mode = 1'b1;
    setup(8'h28, 8'h02, 8'h01);
    pulse(8'h40);
    cas_in = 3'd3; ack();
    chk("R13 other id silent", vec_valid, 0);
    chk("R13 irr kept", cmd_rdata, 8'h40);
    cas_in = 3'd2; ack();
    chk("R13 own id valid", vec_valid, 1);
    chk("R13 own id vector", vec_out, 8'h2E);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule